// File: doc/BRIEF.md
# Stateful Bus Access Guard

This block sits on a shared bus between the requesting masters (processor cores) and the slaves behind it. Every request is judged before it can reach a slave. The request address is compared against all protected address windows at once. Each window is a fixed upper-bit value with a mask of don't-care low bits. The lowest-numbered matching window gives a window ID. That ID, the requesting master's module ID and the operation code together form one access descriptor.

A small policy automaton judges the descriptor. The automaton's grant set changes when it sees certain legal control writes, so the same request can be allowed at one moment and refused later. An allowed request is passed to the slave side one clock later with its fields unchanged. A refused request never reaches the slave side. Instead, the master receives a one-cycle error pulse, and a sticky record keeps the module ID and address of the first refused access.

Top module: `access_guard`

## Requirements
- R1: While reset is asserted and right after it, `fwdValid`, `errResp` and `violFlag` are 0.
- R2: Window i matches when `((reqAddr ^ VALUE[i]) & ~MASK[i]) == 0`. When several windows match, the lowest index is used. An address that matches no window is refused.
- R3: In the base policy, the allowed grants are: module 1 read+write on window 1, module 1 read on window 3, module 2 read+write on window 2, module 3 read+write on window 3, and module 1 and module 3 write on window 0. Every other descriptor is refused.
- R4: Operation codes are 01 = read, 10 = write and 11 = read+write. A request is allowed only if every bit of its code is present in the grant. Code 00 is always refused.
- R5: An allowed request raises `fwdValid` exactly one cycle after `reqValid`, with `fwdModule`, `fwdOp` and `fwdAddr` equal to the request. With no request, `fwdValid` is 0.
- R6: A refused request leaves `fwdValid` at 0 and raises `errResp` for exactly one cycle, one cycle after the request.
- R7: The first refused request sets `violFlag`, records `violModule` and `violAddr`, and these keep their values until reset, even when later requests are refused.
- R8: An allowed write by module 1 to window 0 switches the policy to the shared state. The shared state also grants module 2 read on window 3, starting with the next request. Module 2 write on window 3 stays refused.
- R9: An allowed write by module 3 to window 0 returns the policy to the base state, which removes the extra grant again.
- R10: `fwdValid` and `errResp` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqModule | input | MOD_W | Module ID of the requesting master |
| reqOp | input | 2 | Operation code (01 read, 10 write, 11 both) |
| reqAddr | input | ADDR_W | Request address |
| fwdValid | output | 1 | Allowed request presented to the slave side |
| fwdModule | output | MOD_W | Forwarded module ID |
| fwdOp | output | 2 | Forwarded operation code |
| fwdAddr | output | ADDR_W | Forwarded address |
| errResp | output | 1 | Error response to the master for a refused request |
| violFlag | output | 1 | Sticky: a refused request has occurred |
| violModule | output | MOD_W | Module ID of the first refused request |
| violAddr | output | ADDR_W | Address of the first refused request |

## Verification
The bench builds the block with its default parameters: four windows, with window 1 (64 KiB) lying inside window 2 (1 MiB) at the same base, and window 0 a small 256-byte control window. The nested pair makes the lowest-index rule observable. An address in both windows is judged as window 1, while an address only in window 2 is judged as window 2. An address just past window 3 and one just past window 0 reach the no-match path. The control window lets the bench drive the policy back and forth, and show that the same module 2 read of window 3 is refused, then allowed, then refused again.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [0:0] {
    POL_BASE   = 1'b0,
    POL_SHARED = 1'b1
  } pol_state_e;

  // strobes from the policy control to the datapath
  typedef struct packed {
    logic grant;
    logic deny;
  } guard_strobe_t;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;

endpackage

// File: rtl/guard_range_match.sv
module guard_range_match #(
  parameter int ADDR_W     = 32,
  parameter int NUM_RANGES = 4,
  parameter int ID_W       = 2,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_VALUE = '0,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_MASK  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ID_W-1:0]   rangeId
);

  logic [NUM_RANGES-1:0] matchVec;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
    assign matchVec[i] = ((addr ^ RANGE_VALUE[i]) & ~RANGE_MASK[i]) == '0;
  end

  // lowest index wins: scan from the top down so the last hit kept is lowest
  always_comb begin
    hit     = |matchVec;
    rangeId = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (matchVec[i]) rangeId = ID_W'(i);
    end
  end

endmodule

// File: rtl/guard_policy.sv
module guard_policy
  import guard_pkg::*;
#(
  parameter int MOD_W       = 2,
  parameter int ID_W        = 2,
  parameter int CTRL_WIN    = 0,
  parameter int SHARED_WIN  = 3,
  parameter int OPEN_MOD    = 1,
  parameter int CLOSE_MOD   = 3,
  parameter int GUEST_MOD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MOD_W-1:0]  reqModule,
  input  logic [1:0]        reqOp,
  input  logic              rangeHit,
  input  logic [ID_W-1:0]   rangeId,
  output guard_strobe_t     strb
);

  pol_state_e state, stateNext;
  logic [1:0] perm;
  logic       legal;
  logic       openHit;
  logic       closeHit;

  function automatic logic [1:0] permFor(pol_state_e st, logic [MOD_W-1:0] m,
                                         logic [ID_W-1:0] r);
    logic [1:0] p;
    p = 2'b00;
    if (m == MOD_W'(1) && r == ID_W'(1)) p = 2'b11;
    if (m == MOD_W'(1) && r == ID_W'(SHARED_WIN)) p = 2'b01;
    if (m == MOD_W'(2) && r == ID_W'(2)) p = 2'b11;
    if (m == MOD_W'(3) && r == ID_W'(SHARED_WIN)) p = 2'b11;
    if ((m == MOD_W'(OPEN_MOD) || m == MOD_W'(CLOSE_MOD)) && r == ID_W'(CTRL_WIN))
      p = OP_WRITE;
    if (st == POL_SHARED && m == MOD_W'(GUEST_MOD) && r == ID_W'(SHARED_WIN))
      p = OP_READ;
    return p;
  endfunction

  always_comb begin
    perm  = permFor(state, reqModule, rangeId);
    legal = rangeHit && (reqOp != 2'b00) && ((reqOp & ~perm) == 2'b00);
    strb.grant = reqValid && legal;
    strb.deny  = reqValid && !legal;
  end

  assign openHit  = strb.grant && reqModule == MOD_W'(OPEN_MOD)
                    && rangeId == ID_W'(CTRL_WIN) && reqOp == OP_WRITE;
  assign closeHit = strb.grant && reqModule == MOD_W'(CLOSE_MOD)
                    && rangeId == ID_W'(CTRL_WIN) && reqOp == OP_WRITE;

  always_comb begin
    stateNext = state;
    case (state)
      POL_BASE:   if (openHit)  stateNext = POL_SHARED;
      POL_SHARED: if (closeHit) stateNext = POL_BASE;
      default:    stateNext = POL_BASE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= POL_BASE;
    else       state <= stateNext;
  end

  // R2: an unmatched address is never granted
  assert_nomatch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rangeHit) |-> (strb.deny && !strb.grant));

  // R4: the empty operation code is always refused
  assert_nullop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b00) |-> strb.deny);

  // R8: the policy state only moves on a granted request
  assert_stepgrant_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(state) |-> $past(strb.grant));

endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MOD_W      = 2,
  parameter int NUM_RANGES = 4,
  parameter int ID_W       = 2,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_VALUE = '0,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_MASK  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MOD_W-1:0]  reqModule,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  guard_strobe_t     strb,
  output logic              rangeHit,
  output logic [ID_W-1:0]   rangeId,
  output logic              fwdValid,
  output logic [MOD_W-1:0]  fwdModule,
  output logic [1:0]        fwdOp,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              errResp,
  output logic              violFlag,
  output logic [MOD_W-1:0]  violModule,
  output logic [ADDR_W-1:0] violAddr
);

  guard_range_match #(
    .ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES), .ID_W(ID_W),
    .RANGE_VALUE(RANGE_VALUE), .RANGE_MASK(RANGE_MASK)
  ) u_match (
    .addr(reqAddr), .hit(rangeHit), .rangeId(rangeId)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid   <= 1'b0;
      fwdModule  <= '0;
      fwdOp      <= '0;
      fwdAddr    <= '0;
      errResp    <= 1'b0;
      violFlag   <= 1'b0;
      violModule <= '0;
      violAddr   <= '0;
    end else begin
      fwdValid <= reqValid && strb.grant;
      errResp  <= reqValid && strb.deny;
      if (reqValid && strb.grant) begin
        fwdModule <= reqModule;
        fwdOp     <= reqOp;
        fwdAddr   <= reqAddr;
      end
      if (reqValid && strb.deny && !violFlag) begin
        violFlag   <= 1'b1;
        violModule <= reqModule;
        violAddr   <= reqAddr;
      end
    end
  end

  // R5: a forward always traces back to a request one cycle earlier
  assert_fwdlat_R5: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> $past(reqValid));

  // R6: an error pulse always traces back to a request one cycle earlier
  assert_errlat_R6: assert property (@(posedge clk) disable iff (!rstN)
    errResp |-> $past(reqValid));

  // R7: the violation record never changes once set
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |=> (violFlag && $stable(violAddr) && $stable(violModule)));

  // R10: forward and error are exclusive
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && errResp));

endmodule

// File: rtl/access_guard.sv
module access_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MOD_W      = 2,
  parameter int NUM_RANGES = 4,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_VALUE = {
    32'h3000_0000, 32'h1000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_MASK = {
    32'h0000_FFFF, 32'h000F_FFFF, 32'h0000_FFFF, 32'h0000_00FF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MOD_W-1:0]  reqModule,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              fwdValid,
  output logic [MOD_W-1:0]  fwdModule,
  output logic [1:0]        fwdOp,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              errResp,
  output logic              violFlag,
  output logic [MOD_W-1:0]  violModule,
  output logic [ADDR_W-1:0] violAddr
);

  localparam int ID_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

  guard_strobe_t       strb;
  logic                rangeHit;
  logic [ID_W-1:0]     rangeId;

  guard_policy #(.MOD_W(MOD_W), .ID_W(ID_W)) u_policy (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqModule(reqModule),
    .reqOp(reqOp), .rangeHit(rangeHit), .rangeId(rangeId), .strb(strb)
  );

  guard_datapath #(
    .ADDR_W(ADDR_W), .MOD_W(MOD_W), .NUM_RANGES(NUM_RANGES), .ID_W(ID_W),
    .RANGE_VALUE(RANGE_VALUE), .RANGE_MASK(RANGE_MASK)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqModule(reqModule),
    .reqOp(reqOp), .reqAddr(reqAddr), .strb(strb),
    .rangeHit(rangeHit), .rangeId(rangeId),
    .fwdValid(fwdValid), .fwdModule(fwdModule), .fwdOp(fwdOp), .fwdAddr(fwdAddr),
    .errResp(errResp), .violFlag(violFlag), .violModule(violModule),
    .violAddr(violAddr)
  );

endmodule

// File: tb/access_guard_bench.sv
`timescale 1ns/1ps
module access_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqModule = '0;
  logic [1:0]  reqOp = '0;
  logic [31:0] reqAddr = '0;
  logic        fwdValid, errResp, violFlag;
  logic [1:0]  fwdModule, fwdOp, violModule;
  logic [31:0] fwdAddr, violAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit seenViol = 1'b0;
  logic [1:0]  expViolMod = '0;
  logic [31:0] expViolAddr = '0;

  always #10 clk = ~clk;

  access_guard u_access_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqModule(reqModule),
    .reqOp(reqOp), .reqAddr(reqAddr), .fwdValid(fwdValid), .fwdModule(fwdModule),
    .fwdOp(fwdOp), .fwdAddr(fwdAddr), .errResp(errResp), .violFlag(violFlag),
    .violModule(violModule), .violAddr(violAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; outputs sampled at the falling edge after the capturing edge
  task automatic access(input logic [1:0] m, input logic [1:0] op,
                        input logic [31:0] a, input bit expLegal, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqModule = m; reqOp = op; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check(fwdValid == expLegal && errResp == !expLegal, tag,
          {fwdValid, errResp}, {expLegal, !expLegal});
    if (expLegal)
      check(fwdAddr == a && fwdOp == op && fwdModule == m, {tag, " R5 fields"},
            {fwdModule, fwdOp, fwdAddr}, {m, op, a});
    else if (!seenViol) begin
      seenViol = 1'b1; expViolMod = m; expViolAddr = a;
    end
    check(!(fwdValid && errResp), "R10 exclusive", {fwdValid, errResp}, 2'b00);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!fwdValid && !errResp && !violFlag, "R1 in reset",
          {fwdValid, errResp, violFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!fwdValid && !errResp && !violFlag, "R1 after reset",
          {fwdValid, errResp, violFlag}, 0);
  endtask

  task automatic t_base();
    access(2'd1, 2'b11, 32'h1000_0004, 1'b1, "R3 m1 rw win1");
    access(2'd1, 2'b01, 32'h3000_0100, 1'b1, "R3 m1 read win3");
    access(2'd1, 2'b10, 32'h3000_0200, 1'b0, "R4 m1 write win3 refused");
    access(2'd2, 2'b11, 32'h1008_0000, 1'b1, "R3 m2 rw win2");
    access(2'd3, 2'b10, 32'h3000_FFFC, 1'b1, "R4 m3 write win3 via rw grant");
    access(2'd3, 2'b01, 32'h3000_0000, 1'b1, "R4 m3 read win3 via rw grant");
    access(2'd2, 2'b01, 32'h3000_0100, 1'b0, "R8 m2 read win3 base refused");
    access(2'd1, 2'b00, 32'h1000_0004, 1'b0, "R4 null op refused");
    access(2'd0, 2'b01, 32'h1000_0004, 1'b0, "R3 module 0 refused");
  endtask

  task automatic t_priority();
    access(2'd2, 2'b01, 32'h1000_0010, 1'b0, "R2 overlap picks win1");
    access(2'd1, 2'b01, 32'h1000_0010, 1'b1, "R2 overlap m1 allowed");
    access(2'd1, 2'b01, 32'h3001_0000, 1'b0, "R2 just past win3");
    access(2'd1, 2'b10, 32'h0000_0100, 1'b0, "R2 just past win0");
  endtask

  task automatic t_idle();
    @(negedge clk);
    check(!fwdValid && !errResp, "R5 idle no output", {fwdValid, errResp}, 0);
    access(2'd2, 2'b10, 32'h1000_0000 + 32'h0001_0000, 1'b1, "R5 m2 write win2");
    @(negedge clk);
    check(!fwdValid && !errResp, "R6 single-cycle pulse", {fwdValid, errResp}, 0);
  endtask

  task automatic t_sticky();
    check(violFlag && violModule == expViolMod && violAddr == expViolAddr,
          "R7 first violation recorded", {violFlag, violModule, violAddr},
          {1'b1, expViolMod, expViolAddr});
    access(2'd3, 2'b01, 32'h7000_0000, 1'b0, "R7 later refusal");
    check(violModule == expViolMod && violAddr == expViolAddr,
          "R7 record unchanged", {violModule, violAddr}, {expViolMod, expViolAddr});
  endtask

  task automatic t_policy();
    access(2'd1, 2'b10, 32'h0000_0010, 1'b1, "R8 m1 control write");
    access(2'd2, 2'b01, 32'h3000_0100, 1'b1, "R8 m2 read win3 shared");
    access(2'd2, 2'b10, 32'h3000_0100, 1'b0, "R8 m2 write win3 still refused");
    access(2'd1, 2'b01, 32'h3000_0040, 1'b1, "R8 m1 read win3 kept");
    access(2'd3, 2'b10, 32'h0000_0020, 1'b1, "R9 m3 control write");
    access(2'd2, 2'b01, 32'h3000_0100, 1'b0, "R9 m2 read win3 revoked");
    access(2'd1, 2'b10, 32'h0000_0010, 1'b1, "R8 reopen");
    access(2'd2, 2'b01, 32'h3000_0008, 1'b1, "R8 reopened read");
  endtask

  initial begin
    t_reset();
    t_base();
    t_priority();
    t_idle();
    t_sticky();
    t_policy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule